// File: doc/BRIEF.md
# Flash Bus-Cycle Decoder with Power States

This block sits on the device side of an asynchronous NOR-style flash bus. It oversamples the four active-low bus strobes with a fast system clock: chip select, output enable, write enable and hardware reset. The address and data buses are oversampled in the same way. Each sampled bus state is sorted into one of five cycle kinds. From that kind the block drives the output enables for the 16-bit data bus and for the wait pin.

For a write cycle, the block captures the address and data that were on the bus while the cycle was open. It issues a single one-clock write pulse on the first strobe that closes the cycle, whether that is write enable or chip select. This pulse goes to a downstream command interpreter.

The block also tracks a power state. After a read, once the address has been quiet for a set number of clocks, it drops on its own into automatic power savings. Deselection puts it into standby, unless the program/erase engine reports that it is busy. Hardware reset forces a reset state and returns the read mode to array data. The read mode is held as a flag that the command interpreter can switch to status.

Top module: `flash_bus_ctrl`

## Requirements
- R1: Bus state is classified from the synchronised strobes into `cyc_kind` with codes 0 reset, 1 standby, 2 output-disable, 3 read and 4 write. Reset (0) applies whenever `hw_reset_n` is low. Standby (1) applies whenever `sel_n` is high. Read (3) needs `wr_n` high and `rd_n` low. Write (4) needs `wr_n` low and `rd_n` high. Any other selected state, including `rd_n` and `wr_n` both low, is output-disable (2).
- R2: `dq_oe` and `wait_oe` are high only during a read cycle. Whenever `rd_n` is high, both are low.
- R3: With `sel_n` high, both output enables are low whatever the level of `rd_n`.
- R4: A write cycle produces exactly one `wr_pulse`, on whichever of `wr_n` or `sel_n` rises first. The later rise of the same cycle produces no further pulse.
- R5: When `wr_n` and `sel_n` rise in the same sample, exactly one `wr_pulse` is produced.
- R6: During `wr_pulse`, `wr_addr` and `wr_data` hold the address and data that were present while the write cycle was open.
- R7: No write pulse is produced while `hw_reset_n` is low, even if `wr_n` rises.
- R8: `pwr_state` codes are 00 active, 01 automatic power savings, 10 standby and 11 reset. After a read, `pwr_state` moves from 00 to 01 exactly QUIET_CYC clocks after the read begins, if the address is held constant.
- R9: An address change or a new read returns `pwr_state` to 00 and restarts the quiet count.
- R10: With `sel_n` high, `pwr_state` is 10 when `pe_busy` is low. While `pe_busy` is high, `pwr_state` stays 00, and it moves to 10 once `pe_busy` clears.
- R11: `hw_reset_n` low sets `pwr_state` to 11 and sets `read_array` to 1. `status_sel` clears `read_array` to 0 when `hw_reset_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset for the flops |
| sel_n | input | 1 | Bus chip select, active low |
| rd_n | input | 1 | Bus output enable, active low |
| wr_n | input | 1 | Bus write enable, active low |
| hw_reset_n | input | 1 | Bus hardware reset, active low |
| addr_in | input | AW | Bus address |
| data_in | input | DW | Bus write data |
| pe_busy | input | 1 | Program/erase in progress |
| status_sel | input | 1 | Command interpreter selects status read mode |
| cyc_kind | output | 3 | Classified cycle kind |
| dq_oe | output | 1 | Data bus output enable |
| wait_oe | output | 1 | Wait pin output enable |
| wr_pulse | output | 1 | One-clock write command pulse |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |
| pwr_state | output | 2 | Power state |
| read_array | output | 1 | 1 when reads return array data, 0 for status |

## Verification
The assertions assume that each strobe and each bus value stays steady for at least the two synchroniser clocks. Under that assumption a write's address and data are settled before its closing edge, and a glitch never shorter than a sample can be seen. The bench changes inputs only on falling clock edges and holds every bus state for several clocks. In every write it sets the address and data in the same step as the opening strobe, or earlier. `pe_busy` and `status_sel` are treated as synchronous to the clock and are driven on falling edges.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [2:0] {
    KIND_RESET  = 3'd0,
    KIND_STBY   = 3'd1,
    KIND_OUTDIS = 3'd2,
    KIND_READ   = 3'd3,
    KIND_WRITE  = 3'd4
  } cyc_kind_t;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_APS    = 2'b01,
    PWR_STBY   = 2'b10,
    PWR_RESET  = 2'b11
  } pwr_t;

  // Sort one sampled bus state into a cycle kind (all strobes active low).
  function automatic cyc_kind_t classify(input logic hw_n, input logic sel,
                                         input logic rd, input logic wr);
    cyc_kind_t k;
    if (!hw_n)                k = KIND_RESET;
    else if (sel)             k = KIND_STBY;
    else if (wr && !rd)       k = KIND_READ;
    else if (!wr && rd)       k = KIND_WRITE;
    else                      k = KIND_OUTDIS;
    return k;
  endfunction

  // Next quiet-count value: restart on activity, saturate at the limit.
  function automatic int unsigned quiet_next(input int unsigned cnt,
                                             input logic restart,
                                             input int unsigned limit);
    if (restart)           return 0;
    else if (cnt >= limit) return limit;
    else                   return cnt + 1;
  endfunction

endpackage

// File: rtl/fb_sync.sv
module fb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= INIT;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= INIT;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fb_write_capture.sv
module fb_write_capture
  import flash_bus_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_kind_t     kind,
  input  logic          sel_s,
  input  logic          wr_s,
  input  logic          hw_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic wr_open_q;      // previous sample was inside a write cycle
  logic close_edge;     // first strobe rise that ends the open write

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open_q <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_open_q <= (kind == KIND_WRITE);
      if (kind == KIND_WRITE) begin
        wr_addr <= addr_s;
        wr_data <= data_s;
      end
    end
  end

  assign close_edge = wr_open_q && (wr_s || sel_s);
  assign wr_pulse   = close_edge && hw_s;

  // R4/R5: one pulse per cycle, never two in a row
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  // R7: reset sampled low blocks the pulse
  a_r7_no_pulse_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_s |-> !wr_pulse);
  // R6: captured address is stable on the pulse
  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> $stable(wr_addr));
endmodule

// File: rtl/fb_power.sv
module fb_power
  import flash_bus_pkg::*;
#(
  parameter int AW = 22,
  parameter int QUIET_CYC = 8,
  localparam int CW = $clog2(QUIET_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_kind_t     kind,
  input  logic [AW-1:0] addr_s,
  input  logic          pe_busy,
  output pwr_t          pwr
);
  logic [AW-1:0] addr_prev;
  cyc_kind_t     kind_prev;
  logic [CW-1:0] cnt;
  logic          read_seen;
  logic          addr_moved;   // address changed since last sample
  logic          read_start;   // first sample of a read cycle
  logic          wake;         // activity that forces active
  logic          quiet_done;   // quiet window elapsed after a read

  assign addr_moved = (addr_s != addr_prev);
  assign read_start = (kind == KIND_READ) && (kind_prev != KIND_READ);
  assign wake       = addr_moved || read_start || (pwr == PWR_STBY) || (pwr == PWR_RESET);
  assign quiet_done = (int'(cnt) == QUIET_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_prev <= '0;
      kind_prev <= KIND_RESET;
      cnt       <= '0;
      read_seen <= 1'b0;
      pwr       <= PWR_RESET;
    end else begin
      addr_prev <= addr_s;
      kind_prev <= kind;
      case (kind)
        KIND_RESET: begin
          pwr <= PWR_RESET; cnt <= '0; read_seen <= 1'b0;
        end
        KIND_STBY: begin
          pwr <= pe_busy ? PWR_ACTIVE : PWR_STBY; cnt <= '0; read_seen <= 1'b0;
        end
        KIND_WRITE: begin
          pwr <= PWR_ACTIVE; cnt <= '0; read_seen <= 1'b0;
        end
        default: begin
          if (kind == KIND_READ) read_seen <= 1'b1;
          if (wake) begin
            pwr <= PWR_ACTIVE;
            cnt <= '0;
          end else if (pwr == PWR_ACTIVE && (read_seen || kind == KIND_READ)) begin
            if (quiet_done) pwr <= PWR_APS;
            cnt <= CW'(quiet_next(int'(cnt), 1'b0, QUIET_CYC));
          end
        end
      endcase
    end
  end

  // R10: deselect while busy keeps active
  a_r10_busy_active: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_STBY && pe_busy) |=> pwr == PWR_ACTIVE);
  // R8: savings is only entered from active
  a_r8_aps_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr == PWR_APS) |-> $past(pwr) == PWR_ACTIVE);
  // R9: address movement wakes the block
  a_r9_addr_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_moved && (kind == KIND_READ || kind == KIND_OUTDIS)) |=> pwr == PWR_ACTIVE);
  // R11: reset kind forces reset power state
  a_r11_reset_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_RESET) |=> pwr == PWR_RESET);
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16,
  parameter int QUIET_CYC = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          sys_rst_n,
  input  logic          sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          hw_reset_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic          pe_busy,
  input  logic          status_sel,
  output logic [2:0]    cyc_kind,
  output logic          dq_oe,
  output logic          wait_oe,
  output logic          wr_pulse,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [1:0]    pwr_state
  ,output logic         read_array
);
  localparam int BW = 4 + AW + DW;

  logic [BW-1:0] bus_raw, bus_s;
  logic          sel_s, rd_s, wr_s, hw_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;
  cyc_kind_t     kind;
  pwr_t          pwr;

  assign bus_raw = {hw_reset_n, sel_n, rd_n, wr_n, addr_in, data_in};

  fb_sync #(.W(BW), .STAGES(SYNC_STAGES), .INIT({4'b1111, {(AW+DW){1'b0}}})) u_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(bus_raw), .q(bus_s));

  assign {hw_s, sel_s, rd_s, wr_s, addr_s, data_s} = bus_s;

  assign kind     = classify(hw_s, sel_s, rd_s, wr_s);
  assign cyc_kind = kind;
  assign dq_oe    = (kind == KIND_READ);
  assign wait_oe  = dq_oe;

  fb_write_capture #(.AW(AW), .DW(DW)) u_wcap (
    .clk(clk), .rst_n(sys_rst_n), .kind(kind), .sel_s(sel_s), .wr_s(wr_s),
    .hw_s(hw_s), .addr_s(addr_s), .data_s(data_s),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data));

  fb_power #(.AW(AW), .QUIET_CYC(QUIET_CYC)) u_pwr (
    .clk(clk), .rst_n(sys_rst_n), .kind(kind), .addr_s(addr_s),
    .pe_busy(pe_busy), .pwr(pwr));

  assign pwr_state = pwr;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)       read_array <= 1'b1;
    else if (!hw_s)       read_array <= 1'b1;
    else if (status_sel)  read_array <= 1'b0;
  end

  // R2: output drivers off whenever output enable is sampled high
  a_r2_oe_off: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rd_s |-> (!dq_oe && !wait_oe));
  // R3: deselected means no drive
  a_r3_stby_hiz: assert property (@(posedge clk) disable iff (!sys_rst_n)
    sel_s |-> !dq_oe);
  // R11: reset returns reads to array data
  a_r11_array_mode: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !hw_s |=> read_array);
endmodule

// File: tb/flash_bus_ctrl_bench.sv
module flash_bus_ctrl_bench;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int QC = 8;

  logic clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, hw_reset_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic pe_busy = 1'b0, status_sel = 1'b0;
  logic [2:0] cyc_kind;
  logic dq_oe, wait_oe, wr_pulse, read_array;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0] pwr_state;

  int total = 0, bad = 0, pulses = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] last_d;
  bit done = 0;

  always #5 clk = ~clk;

  flash_bus_ctrl #(.AW(AW), .DW(DW), .QUIET_CYC(QC)) u_flash_bus_ctrl (
    .clk(clk), .sys_rst_n(sys_rst_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
    .hw_reset_n(hw_reset_n), .addr_in(addr_in), .data_in(data_in),
    .pe_busy(pe_busy), .status_sel(status_sel), .cyc_kind(cyc_kind),
    .dq_oe(dq_oe), .wait_oe(wait_oe), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwr_state(pwr_state), .read_array(read_array));

  always @(posedge clk) if (wr_pulse) begin
    pulses++; last_a = wr_addr; last_d = wr_data;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(logic h, logic s, logic r, logic w);
    hw_reset_n = h; sel_n = s; rd_n = r; wr_n = w;
  endtask

  // {hw, sel, rd, wr, kind[2:0], oe}
  localparam logic [7:0] VEC [8] = '{
    {4'b1001, 3'd3, 1'b1}, {4'b1010, 3'd4, 1'b0}, {4'b1011, 3'd2, 1'b0},
    {4'b1101, 3'd1, 1'b0}, {4'b1111, 3'd1, 1'b0}, {4'b0001, 3'd0, 1'b0},
    {4'b0010, 3'd0, 1'b0}, {4'b1000, 3'd2, 1'b0}};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int p0;
    step(3);
    sys_rst_n = 1'b1;
    step(4);
    chk("R11 reset read_array", read_array, 1);
    chk("R10 idle standby", pwr_state, 2'b10);
    chk("R3 idle oe", dq_oe, 0);

    for (int i = 0; i < 8; i++) begin
      bus(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      step(4);
      chk("R1 kind", cyc_kind, VEC[i][3:1]);
      chk("R2 dq_oe", dq_oe, VEC[i][0]);
      chk("R2 wait_oe", wait_oe, VEC[i][0]);
      bus(1, 1, 1, 1);
      step(4);
    end

    // R4: WE rises first, then CE
    p0 = pulses;
    addr_in = 22'h12345; data_in = 16'hBEEF;
    bus(1, 0, 1, 0); step(4);
    bus(1, 0, 1, 1); step(4);
    chk("R4 we-first pulse", pulses - p0, 1);
    chk("R6 addr", last_a, 22'h12345);
    chk("R6 data", last_d, 16'hBEEF);
    bus(1, 1, 1, 1); step(4);
    chk("R4 later ce edge", pulses - p0, 1);

    // R4: CE rises first, then WE
    p0 = pulses;
    addr_in = 22'h0A5A5; data_in = 16'h1234;
    bus(1, 0, 1, 0); step(4);
    bus(1, 1, 1, 0); step(4);
    chk("R4 ce-first pulse", pulses - p0, 1);
    chk("R6 addr ce-first", last_a, 22'h0A5A5);
    bus(1, 1, 1, 1); step(4);
    chk("R4 later we edge", pulses - p0, 1);

    // R5: simultaneous rise
    p0 = pulses;
    data_in = 16'h5AA5;
    bus(1, 0, 1, 0); step(4);
    bus(1, 1, 1, 1); step(4);
    chk("R5 simultaneous", pulses - p0, 1);
    chk("R6 data simultaneous", last_d, 16'h5AA5);

    // R7: reset during write
    p0 = pulses;
    bus(1, 0, 1, 0); step(4);
    bus(0, 0, 1, 0); step(4);
    bus(0, 0, 1, 1); step(4);
    bus(0, 1, 1, 1); step(4);
    chk("R7 no pulse in reset", pulses - p0, 0);
    chk("R11 pwr reset", pwr_state, 2'b11);
    bus(1, 1, 1, 1); step(4);

    // R8: quiet timer after read
    addr_in = 22'h00100;
    bus(1, 0, 0, 1);
    step(3 + QC - 1);
    chk("R8 still active", pwr_state, 2'b00);
    step(1);
    chk("R8 enter aps", pwr_state, 2'b01);
    // R9: address change wakes
    addr_in = 22'h00101;
    step(4);
    chk("R9 wake on addr", pwr_state, 2'b00);
    step(QC + 2);
    chk("R9 aps again", pwr_state, 2'b01);
    bus(1, 0, 1, 1); step(3);
    bus(1, 0, 0, 1); step(4);
    chk("R9 new read wakes", pwr_state, 2'b00);

    // R10: deselect while busy
    pe_busy = 1'b1;
    bus(1, 1, 1, 1); step(4);
    chk("R10 busy keeps active", pwr_state, 2'b00);
    chk("R3 stby oe", dq_oe, 0);
    pe_busy = 1'b0; step(2);
    chk("R10 standby after busy", pwr_state, 2'b10);

    // R11: read mode
    status_sel = 1'b1; step(1); status_sel = 1'b0; step(1);
    chk("R11 status mode", read_array, 0);
    bus(0, 1, 1, 1); step(4);
    chk("R11 array after reset", read_array, 1);
    bus(1, 1, 1, 1); step(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule